// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Controller

This block sits between an on-chip request port and an external asynchronous static RAM. A client presents one single-word read or write at a time on a valid/ready handshake. The controller turns it into the memory strobes: the address, a split data bus (drive value, drive enable, sampled input), two chip enables of opposite polarity, a write strobe and an output-enable strobe. Each strobe is registered, so every pin changes only on the controller clock.

Each phase length is a whole number of clock periods. The count comes from a picosecond minimum for the chosen speed grade and a clock-period parameter, rounded up when the design is elaborated. A write is the overlap of both chip enables and a low write strobe. The controller always ends that overlap by raising the write strobe while both enables stay active and the data stays driven. A read releases the bus, then lowers output enable for the access count and samples the word on the last clock of that count. It returns the word with a one-clock valid pulse. A write issued just after a read waits until the memory's outputs have had time to float.

Top module: `async_sram_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, the outputs are idle: chip enable 1 (active low) is 1, chip enable 2 (active high) is 0, the write strobe is 1, output enable is 1, the bus drive enable is 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. Its address and write data are registered on that edge. They stay unchanged on `sram_addr` and `sram_dq_out` until the controller is ready again, whatever the request inputs do in the meantime.
- R3: The write strobe is 0 only while both chip enables are active. Each low pulse lasts exactly WP clocks, where WP is the largest of the tick counts for the write pulse, data setup, address-to-end and enable-to-end minimums. When the strobe rises, both enables are still active and the bus is still driven.
- R4: With no read turnaround pending, a write keeps `req_ready` at 0 for WP + WEND clocks. WEND is the write-cycle tick count minus WP, but never less than 1.
- R5: A read spends one clock with the enables active and output enable at 1. It then holds output enable at 0 for exactly RA clocks, where RA = max(address-access ticks, output-enable-access ticks, read-cycle ticks − 1, 1). The word on `sram_dq_in` at the edge that ends the last of those clocks appears on `rsp_rdata` with `rsp_valid` at 1 for exactly one clock, and that is the clock in which `req_ready` returns to 1.
- R6: The bus is driven only during a write, from the clock the write strobe falls through the clock after it rises, and never while output enable is 0. A read releases the bus at least one clock before output enable falls.
- R7: After output enable rises, the bus is not driven until at least OZ clocks have passed, where OZ is the output-enable-to-float tick count. A write that is requested back to back with a read is lengthened by the clocks it waits.
- R8: While a cycle is in progress, `req_ready` is 0 and a held `req_valid` is not taken. The held request is taken on the first edge where `req_ready` is 1 and then runs as a full cycle of its own.
- R9: Each minimum converts to ceiling(ps / CLK_PS) clocks, and at least 1 when the minimum is nonzero. GRADE 0 selects the faster timing set and GRADE 1 the slower one.
- R10: A read of an address returns the word most recently written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | One-clock pulse with read data |
| rsp_rdata | output | DW | Read data |
| sram_addr | output | AW | Memory address |
| sram_dq_out | output | DW | Data driven onto the memory bus |
| sram_dq_oe | output | 1 | Bus drive enable |
| sram_dq_in | input | DW | Data sampled from the memory bus |
| sram_ce1_n | output | 1 | Chip enable, active low |
| sram_ce2 | output | 1 | Chip enable, active high |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_oe_n | output | 1 | Output enable, active low |

## Verification
The bench runs the slower grade at a short configured period, so every phase lasts several clocks and an off-by-one count changes the measured cycle lengths. Its memory model returns a junk word until both access windows have elapsed. A controller that samples one clock early therefore returns junk rather than the stored data. The model also counts how long output enable has been high whenever the bus is driven. A write that is not held back after a read shows up as a contention failure, and so does a design that skips the release clock before output enable falls. A request held during a busy cycle checks that the address and data pins do not follow the inputs and that the second request is neither lost nor merged into the first.

// File: rtl/sram_ctrl_pkg.sv
// Shared types and elaboration-time helpers for the static RAM controller.
// Assumes timing minimums in picoseconds and a positive clock period.
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE    = 3'd0,
        SEQ_WGAP    = 3'd1,
        SEQ_WPULSE  = 3'd2,
        SEQ_WEND    = 3'd3,
        SEQ_RSETUP  = 3'd4,
        SEQ_RACCESS = 3'd5
    } seq_state_e;

    typedef enum int unsigned {
        TM_RC, TM_AA, TM_DOE, TM_HZOE, TM_WC, TM_PWE, TM_SD, TM_AW, TM_SCE
    } tmin_e;

    // Minimum in picoseconds for one timing item and one speed grade.
    function automatic int unsigned min_ps(int unsigned grade, tmin_e k);
        case (k)
            TM_RC:   return (grade == 0) ? 15000 : 20000;
            TM_AA:   return (grade == 0) ? 15000 : 20000;
            TM_DOE:  return (grade == 0) ?  7000 :  9000;
            TM_HZOE: return (grade == 0) ?  7000 :  9000;
            TM_WC:   return (grade == 0) ? 15000 : 20000;
            TM_PWE:  return (grade == 0) ? 10000 : 15000;
            TM_SD:   return (grade == 0) ?  8000 : 10000;
            TM_AW:   return (grade == 0) ? 10000 : 15000;
            TM_SCE:  return (grade == 0) ? 10000 : 15000;
            default: return 0;
        endcase
    endfunction

    // Round a picosecond minimum up to whole clock periods.
    function automatic int unsigned to_ticks(int unsigned ps, int unsigned clk_ps);
        if (ps == 0) return 0;
        return (ps + clk_ps - 1) / clk_ps;
    endfunction

    function automatic int unsigned max_u(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Bits needed to hold values 0..v, never fewer than one.
    function automatic int unsigned bits_for(int unsigned v);
        return (v <= 1) ? 1 : $clog2(v + 1);
    endfunction

endpackage

// File: rtl/sram_ctrl_seq.sv
// Cycle sequencer: walks one request through its phases, times each phase
// with a down counter and tracks the bus float window left by a read.
// Assumes phase lengths of at least one clock.
module sram_ctrl_seq
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned N_WP   = 1,
    parameter int unsigned N_WEND = 1,
    parameter int unsigned N_RACC = 1,
    parameter int unsigned N_OEZ  = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       req_write,
    output logic       req_ready,
    output logic       accept,
    output logic       capture,
    output seq_state_e st_d
);

    localparam int unsigned CNT_MAX = max_u(max_u(N_WP, N_WEND), N_RACC);
    localparam int unsigned CW      = bits_for(CNT_MAX);
    localparam int unsigned FW      = bits_for(N_OEZ);

    seq_state_e     st_q;
    logic [CW-1:0]  cnt_q;
    logic [FW-1:0]  float_q;
    logic           phase_done;
    logic           float_clear;

    assign phase_done  = (cnt_q == '0);
    assign float_clear = (float_q == '0) || (float_q == FW'(1));
    assign req_ready   = (st_q == SEQ_IDLE);
    assign accept      = req_valid && req_ready;
    assign capture     = (st_q == SEQ_RACCESS) && phase_done;

    // Counter preload for a phase being entered.
    function automatic logic [CW-1:0] phase_len(seq_state_e s);
        case (s)
            SEQ_WPULSE:  return CW'(N_WP - 1);
            SEQ_WEND:    return CW'(N_WEND - 1);
            SEQ_RACCESS: return CW'(N_RACC - 1);
            default:     return '0;
        endcase
    endfunction

    // Next-phase selection.
    always_comb begin
        st_d = st_q;
        case (st_q)
            SEQ_IDLE: begin
                if (accept) begin
                    if (req_write) st_d = float_clear ? SEQ_WPULSE : SEQ_WGAP;
                    else           st_d = SEQ_RSETUP;
                end
            end
            SEQ_WGAP:    if (float_clear) st_d = SEQ_WPULSE;
            SEQ_WPULSE:  if (phase_done)  st_d = SEQ_WEND;
            SEQ_WEND:    if (phase_done)  st_d = SEQ_IDLE;
            SEQ_RSETUP:                   st_d = SEQ_RACCESS;
            SEQ_RACCESS: if (phase_done)  st_d = SEQ_IDLE;
            default:                      st_d = SEQ_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= SEQ_IDLE;
        else        st_q <= st_d;
    end

    // Phase timer: preload on a phase change, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt_q <= '0;
        else if (st_d != st_q)    cnt_q <= phase_len(st_d);
        else if (!phase_done)     cnt_q <= cnt_q - CW'(1);
    end

    // Float window: armed when output enable is released, then drains.
    always_ff @(posedge clk) begin
        if (!rst_n)                                    float_q <= '0;
        else if ((st_q == SEQ_RACCESS) && phase_done)  float_q <= FW'(N_OEZ);
        else if (float_q != '0)                        float_q <= float_q - FW'(1);
    end

    // R7: the gap phase is only ever occupied while a float window remains.
    p_gap_has_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SEQ_WGAP) |-> (float_q != '0));

    // R8: with no request offered, an idle controller stays idle.
    p_idle_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !req_valid) |=> req_ready);

endmodule

// File: rtl/sram_ctrl_pins.sv
// Strobe generator: registers the chip enables, write strobe, output enable
// and bus drive enable from the next phase, so pins change only on the clock.
// Assumes the sequencer never moves between read and write phases directly.
module sram_ctrl_pins
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned N_WP  = 1,
    parameter int unsigned N_OEZ = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  seq_state_e st_d,
    output logic       sram_ce1_n,
    output logic       sram_ce2,
    output logic       sram_we_n,
    output logic       sram_oe_n,
    output logic       sram_dq_oe
);

    localparam int unsigned WW = bits_for(N_WP + 1);
    localparam int unsigned OW = bits_for(N_OEZ);

    logic [WW-1:0] we_low_cnt;
    logic [OW-1:0] oe_hi_cnt;

    // Registered strobe decode from the phase about to be entered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sram_ce1_n <= 1'b1;
            sram_ce2   <= 1'b0;
            sram_we_n  <= 1'b1;
            sram_oe_n  <= 1'b1;
            sram_dq_oe <= 1'b0;
        end else begin
            sram_ce1_n <= (st_d == SEQ_IDLE);
            sram_ce2   <= (st_d != SEQ_IDLE);
            sram_we_n  <= (st_d != SEQ_WPULSE);
            sram_oe_n  <= (st_d != SEQ_RACCESS);
            sram_dq_oe <= (st_d == SEQ_WPULSE) || (st_d == SEQ_WEND);
        end
    end

    // Length of the current write strobe pulse, for the pulse-width check.
    always_ff @(posedge clk) begin
        if (!rst_n)                           we_low_cnt <= '0;
        else if (sram_we_n)                   we_low_cnt <= '0;
        else if (we_low_cnt != {WW{1'b1}})    we_low_cnt <= we_low_cnt + WW'(1);
    end

    // Clocks since output enable went high, saturating at the float count.
    always_ff @(posedge clk) begin
        if (!rst_n)                           oe_hi_cnt <= OW'(N_OEZ);
        else if (!sram_oe_n)                  oe_hi_cnt <= '0;
        else if (oe_hi_cnt < OW'(N_OEZ))      oe_hi_cnt <= oe_hi_cnt + OW'(1);
    end

    // R3: every write strobe pulse is exactly the derived width.
    p_we_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (we_low_cnt == WW'(N_WP)));

    // R3: the write ends on the strobe while enables and data are still up.
    p_we_ends_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (!sram_ce1_n && sram_ce2 && sram_dq_oe));

    // R6: no drive while the memory is allowed to drive.
    p_no_drive_with_oe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> sram_oe_n);

    // R7: drive starts only after the float time has passed.
    p_float_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_dq_oe) |-> (oe_hi_cnt >= OW'(N_OEZ)));

endmodule

// File: rtl/sram_ctrl_dpath.sv
// Data path: holds the accepted address and write word for the whole cycle,
// and captures the read word into a one-clock response.
// Assumes capture is asserted on the last access clock only.
module sram_ctrl_dpath #(
    parameter int unsigned AW = 16,
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          capture,
    input  logic [DW-1:0] sram_dq_in,
    output logic [AW-1:0] sram_addr,
    output logic [DW-1:0] sram_dq_out,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata
);

    // Request registers, loaded only on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sram_addr   <= '0;
            sram_dq_out <= '0;
        end else if (accept) begin
            sram_addr   <= req_addr;
            sram_dq_out <= req_wdata;
        end
    end

    // Read capture and response pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= capture;
            if (capture) rsp_rdata <= sram_dq_in;
        end
    end

    // R5: a response lasts exactly one clock.
    p_rsp_one_clock_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/async_sram_ctrl.sv
// Top of the static RAM controller: derives the phase counts for the chosen
// grade and clock period, and connects sequencer, strobes and data path.
// Assumes one outstanding request and a memory with zero address setup/hold.
module async_sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned AW     = 16,
    parameter int unsigned DW     = 16,
    parameter int unsigned CLK_PS = 20000,
    parameter int unsigned GRADE  = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic [AW-1:0] sram_addr,
    output logic [DW-1:0] sram_dq_out,
    output logic          sram_dq_oe,
    input  logic [DW-1:0] sram_dq_in,
    output logic          sram_ce1_n,
    output logic          sram_ce2,
    output logic          sram_we_n,
    output logic          sram_oe_n
);

    localparam int unsigned N_RC   = to_ticks(min_ps(GRADE, TM_RC),   CLK_PS);
    localparam int unsigned N_AA   = to_ticks(min_ps(GRADE, TM_AA),   CLK_PS);
    localparam int unsigned N_DOE  = to_ticks(min_ps(GRADE, TM_DOE),  CLK_PS);
    localparam int unsigned N_HZOE = to_ticks(min_ps(GRADE, TM_HZOE), CLK_PS);
    localparam int unsigned N_WC   = to_ticks(min_ps(GRADE, TM_WC),   CLK_PS);
    localparam int unsigned N_PWE  = to_ticks(min_ps(GRADE, TM_PWE),  CLK_PS);
    localparam int unsigned N_SD   = to_ticks(min_ps(GRADE, TM_SD),   CLK_PS);
    localparam int unsigned N_AW   = to_ticks(min_ps(GRADE, TM_AW),   CLK_PS);
    localparam int unsigned N_SCE  = to_ticks(min_ps(GRADE, TM_SCE),  CLK_PS);

    localparam int unsigned N_WP   = max_u(max_u(N_PWE, N_SD), max_u(N_AW, N_SCE));
    localparam int unsigned N_WEND = (N_WC > N_WP) ? (N_WC - N_WP) : 1;
    localparam int unsigned N_RACC = max_u(max_u(N_AA, N_DOE), (N_RC > 1) ? (N_RC - 1) : 1);
    localparam int unsigned N_OEZ  = max_u(N_HZOE, 1);

    logic       accept;
    logic       capture;
    seq_state_e st_d;

    sram_ctrl_seq #(
        .N_WP   (N_WP),
        .N_WEND (N_WEND),
        .N_RACC (N_RACC),
        .N_OEZ  (N_OEZ)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_ready (req_ready),
        .accept    (accept),
        .capture   (capture),
        .st_d      (st_d)
    );

    sram_ctrl_pins #(
        .N_WP  (N_WP),
        .N_OEZ (N_OEZ)
    ) u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .st_d       (st_d),
        .sram_ce1_n (sram_ce1_n),
        .sram_ce2   (sram_ce2),
        .sram_we_n  (sram_we_n),
        .sram_oe_n  (sram_oe_n),
        .sram_dq_oe (sram_dq_oe)
    );

    sram_ctrl_dpath #(
        .AW (AW),
        .DW (DW)
    ) u_dpath (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .capture     (capture),
        .sram_dq_in  (sram_dq_in),
        .sram_addr   (sram_addr),
        .sram_dq_out (sram_dq_out),
        .rsp_valid   (rsp_valid),
        .rsp_rdata   (rsp_rdata)
    );

    // R2: the address pins hold still across consecutive busy clocks.
    p_addr_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && $past(!req_ready)) |-> $stable(sram_addr));

    // R5: the response arrives together with renewed readiness.
    p_rsp_with_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> req_ready);

endmodule

// File: tb/tb_async_sram_ctrl.sv
// Directed bench with a behavioural memory model that checks strobe timing
// in clock counts and returns junk until its access windows have elapsed.
module tb_async_sram_ctrl;

    localparam int AW     = 8;
    localparam int DW     = 16;
    localparam int CLK_PS = 5000;   // configured period seen by the controller
    localparam int GRADE  = 1;      // slower timing set

    function automatic int ceil_ticks(int ns);
        return (ns * 1000 + CLK_PS - 1) / CLK_PS;
    endfunction
    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

    // R9: expected counts from the slower grade minimums.
    localparam int E_WP   = imax(imax(ceil_ticks(15), ceil_ticks(10)), imax(ceil_ticks(15), ceil_ticks(15)));
    localparam int E_WC   = ceil_ticks(20);
    localparam int E_WEND = (E_WC > E_WP) ? E_WC - E_WP : 1;
    localparam int E_AA   = ceil_ticks(20);
    localparam int E_DOE  = ceil_ticks(9);
    localparam int E_RACC = imax(imax(E_AA, E_DOE), imax(ceil_ticks(20) - 1, 1));
    localparam int E_OEZ  = ceil_ticks(9);
    localparam int E_WRITE = E_WP + E_WEND;
    localparam int E_READ  = 1 + E_RACC;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] sram_addr;
    logic [DW-1:0] sram_dq_out;
    logic          sram_dq_oe;
    logic [DW-1:0] sram_dq_in = '0;
    logic          sram_ce1_n, sram_ce2, sram_we_n, sram_oe_n;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    int we_rises = 0;

    always #10 clk = ~clk;   // 50 MHz

    async_sram_ctrl #(.AW(AW), .DW(DW), .CLK_PS(CLK_PS), .GRADE(GRADE)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .sram_addr(sram_addr), .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe),
        .sram_dq_in(sram_dq_in),
        .sram_ce1_n(sram_ce1_n), .sram_ce2(sram_ce2),
        .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Behavioural memory with timing checks in clock counts.
    logic [DW-1:0] mem [256];
    int            we_low = 0, oe_low = 0, addr_cnt = 0, oe_hi = 100;
    logic          prev_we_n = 1'b1, prev_oe_n = 1'b1;
    logic [AW-1:0] prev_addr = '0;
    logic [DW-1:0] prev_dq = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            automatic logic ce_on = !sram_ce1_n && sram_ce2;
            addr_cnt = (sram_addr == prev_addr) ? addr_cnt + 1 : 1;
            oe_hi    = sram_oe_n ? ((oe_hi < 100) ? oe_hi + 1 : 100) : 0;
            if (!sram_we_n) begin
                we_low++;
                if (!ce_on) check("R3", "strobe low without enables", 1, 0);
                if (we_low > 1 && sram_dq_out != prev_dq) check("R2", "data moved in pulse", 1, 0);
            end else if (!prev_we_n) begin
                we_rises++;
                check("R3", "write strobe width", we_low, E_WP);
                check("R3", "enables and drive at strobe rise", {30'd0, ce_on, sram_dq_oe}, 3);
                mem[sram_addr] = sram_dq_out;
                we_low = 0;
            end
            if (!sram_oe_n) oe_low++;
            else if (!prev_oe_n) begin
                check("R5", "output enable low length", oe_low, E_RACC);
                oe_low = 0;
            end
            if (sram_dq_oe && !sram_oe_n) check("R6", "drive while output enabled", 1, 0);
            if (sram_dq_oe && oe_hi <= E_OEZ) check("R7", "drive inside float time", oe_hi, E_OEZ + 1);
            if (!sram_oe_n && prev_dq_oe_q) check("R6", "bus not released before read", 1, 0);
            if (ce_on && !sram_oe_n && sram_we_n && oe_low >= E_DOE && addr_cnt >= E_AA)
                sram_dq_in <= mem[sram_addr];
            else
                sram_dq_in <= 16'hBAD0;
            prev_we_n = sram_we_n;
            prev_oe_n = sram_oe_n;
            prev_addr = sram_addr;
            prev_dq   = sram_dq_out;
            prev_dq_oe_q = sram_dq_oe;
        end
    end
    logic prev_dq_oe_q = 1'b0;

    // One request; back2back skips the leading idle clock.
    task automatic xfer(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input bit back2back, output int busy, output int rsps,
                        output logic [DW-1:0] rd);
        if (!back2back) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        busy = 0; rsps = 0; rd = '0;
        while (!req_ready) begin
            busy++;
            if (rsp_valid) rsps++;
            @(negedge clk);
        end
        if (rsp_valid) begin rsps++; rd = rsp_rdata; end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1", "strobes in reset", {27'd0, sram_ce1_n, sram_ce2, sram_we_n, sram_oe_n, sram_dq_oe}, 5'b10110);
        check("R1", "rsp_valid in reset", rsp_valid, 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R1", "ready after reset", req_ready, 1);
        check("R1", "strobes after reset", {27'd0, sram_ce1_n, sram_ce2, sram_we_n, sram_oe_n, sram_dq_oe}, 5'b10110);
    endtask

    task automatic t_single();
        int b, r; logic [DW-1:0] rd;
        xfer(1'b1, 8'h12, 16'h5A5A, 0, b, r, rd);
        check("R4", "write busy clocks", b, E_WRITE);
        check("R9", "write length covers cycle minimum", int'(b >= E_WC), 1);
        xfer(1'b0, 8'h12, 16'h0000, 0, b, r, rd);
        check("R5", "read busy clocks", b, E_READ);
        check("R5", "one response pulse", r, 1);
        check("R10", "read back", rd, 16'h5A5A);
    endtask

    task automatic t_pattern();
        int b, r; logic [DW-1:0] rd;
        for (int i = 0; i < 6; i++) xfer(1'b1, AW'(8'h40 + i), DW'(16'h1 << (i * 3)) ^ 16'hF00F, 0, b, r, rd);
        xfer(1'b1, 8'hFF, 16'hFFFF, 0, b, r, rd);
        xfer(1'b1, 8'h00, 16'h0000, 0, b, r, rd);
        for (int i = 5; i >= 0; i--) begin
            xfer(1'b0, AW'(8'h40 + i), '0, 0, b, r, rd);
            check("R10", "pattern read", rd, DW'(16'h1 << (i * 3)) ^ 16'hF00F);
        end
        xfer(1'b0, 8'hFF, '0, 0, b, r, rd);
        check("R10", "all-ones word", rd, 16'hFFFF);
        xfer(1'b0, 8'h00, '0, 0, b, r, rd);
        check("R10", "all-zeros word", rd, 16'h0000);
    endtask

    task automatic t_hold();
        int bad = 0, b, r, w0; logic [DW-1:0] rd;
        w0 = we_rises;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h21; req_wdata = 16'hC3C3;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_addr = 8'h22; req_wdata = 16'h3C3C;   // second request held while busy
        while (!req_ready) begin
            if (sram_addr != 8'h21) bad++;
            if (sram_dq_oe && sram_dq_out != 16'hC3C3) bad++;
            @(negedge clk);
        end
        check("R2", "pins held during busy cycle", bad, 0);
        @(negedge clk);
        req_valid = 1'b0;
        b = 0;
        while (!req_ready) begin
            b++;
            if (sram_addr != 8'h22) bad++;
            @(negedge clk);
        end
        check("R8", "held request ran a full cycle", b, E_WRITE);
        check("R2", "second request pins", bad, 0);
        check("R8", "two separate write pulses", we_rises - w0, 2);
        xfer(1'b0, 8'h21, '0, 0, b, r, rd);
        check("R8", "first held word", rd, 16'hC3C3);
        xfer(1'b0, 8'h22, '0, 0, b, r, rd);
        check("R8", "second held word", rd, 16'h3C3C);
    endtask

    task automatic t_turnaround();
        int b, r; logic [DW-1:0] rd;
        xfer(1'b1, 8'h30, 16'hBEEF, 0, b, r, rd);
        xfer(1'b0, 8'h30, '0, 0, b, r, rd);
        check("R10", "read before turnaround", rd, 16'hBEEF);
        xfer(1'b1, 8'h31, 16'h1234, 1, b, r, rd);
        check("R7", "write after read waits out float", b, E_WRITE + E_OEZ - 1);
        xfer(1'b0, 8'h31, '0, 1, b, r, rd);
        check("R6", "read right after write", rd, 16'h1234);
        check("R6", "read right after write length", b, E_READ);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        t_reset();
        t_single();
        t_pattern();
        t_hold();
        t_turnaround();
        repeat (4) @(negedge clk);
        finish_run();
    end

    initial begin
        #(20 * 50000);
        check("WATCHDOG", "run did not finish", 1, 0);
        finish_run();
    end

endmodule